// File: doc/BRIEF.md
# Multi-Channel Acquisition Sequencer

This block paces a bank of analog inputs that share one analog-to-digital converter through an analog multiplexer. A single clock is divided into equal time slots, one per channel. At the start of each slot the block moves the multiplexer select to the next channel. After a programmable settling delay it pulses a conversion start. When the converter reports end of conversion it reads the result. It then offers the sample, tagged with its channel number, to a downstream FIFO.

With the default of 32 channels sampled at 10 kHz each, the aggregate rate is 320 k conversions per second. The slot length in clocks, `SLOT_CYCLES`, is chosen as the master clock frequency divided by that aggregate rate. The sequence runs while `run` is high. When `run` falls, the block finishes the slot in progress and parks on channel 0.

The FIFO side is a valid/ready stream with a hard real-time rule: a sample cannot wait, because the next slot is already converting. `fifo_valid` is therefore a one-cycle offer. If `fifo_ready` is low in that cycle the sample is lost, and a sticky `overflow` flag records the loss. `fifo_ready` is never required to be high, and the block never stalls.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is held and after it is released with `run` low, `mux_sel` is 0 and `adc_start`, `adc_rd`, `fifo_valid` and `overflow` are all low.
- R2: Every active slot lasts exactly `SLOT_CYCLES` clocks, and `mux_sel` changes only at a slot boundary.
- R3: Channels are visited in ascending order and the select wraps from `NUM_CH-1` to 0. The first slot after idle always uses channel 0.
- R4: `adc_start` is a one-clock pulse issued `settle` clocks after the select changes; a `settle` of 0 places it in the first clock of the slot. A `settle` of `SLOT_CYCLES` or more issues no start in that slot.
- R5: `adc_done` is accepted from the clock after the start up to and including the last clock of the slot. In the accepting clock `adc_rd` is high and `adc_data` is captured. In the next clock `fifo_valid` is high for one clock, with `fifo_data[11:0]` holding the sample and `fifo_data[16:12]` the channel.
- R6: `fifo_data[17]` is a frame-start flag, set exactly when the sample belongs to channel 0.
- R7: `adc_done` outside the acceptance window is ignored. This covers idle, the clocks before the start, and any clock after a result was taken.
- R8: A conversion not reported by the last clock of its slot is abandoned, and no FIFO offer is made for that slot. A start issued in the last clock of a slot therefore never produces a write.
- R9: If `fifo_ready` is low in the clock where `fifo_valid` is high, the sample is dropped and `overflow` goes high. `overflow` then stays high until reset.
- R10: When `run` goes low, the slot in progress runs to its end, including its FIFO offer if the result arrives in time. After that no further starts are issued and `mux_sel` rests at 0. Raising `run` again restarts from channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all timing is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to keep sequencing; low stops after the current slot |
| settle | input | SETTLE_W (8) | Clocks from select change to conversion start |
| mux_sel | output | CH_W (5) | Analog multiplexer channel select |
| adc_start | output | 1 | One-clock conversion start pulse |
| adc_done | input | 1 | End-of-conversion indication from the converter |
| adc_data | input | DATA_W (12) | Conversion result, valid while `adc_done` is high |
| adc_rd | output | 1 | Read strobe, high in the clock the result is taken |
| fifo_valid | output | 1 | One-clock sample offer to the FIFO |
| fifo_ready | input | 1 | FIFO can take a word (low means full) |
| fifo_data | output | DATA_W+CH_W+1 (18) | {frame start, channel, sample} |
| overflow | output | 1 | Sticky flag: a sample was offered while the FIFO was full |

## Verification
Several properties are checked on every clock:
- a stop always lands on a slot boundary;
- the select moves only at slot ends and sits at 0 whenever the sequencer is idle;
- a start and a read never share a clock, and a read only happens inside an active slot;
- every FIFO offer follows a read;
- the overflow flag never clears on its own.

Other behaviours need whole scenarios and are left to the bench's runs:
- the exact settling offset and slot length;
- channel order and wrap, and the frame flag;
- the sample payload;
- the acceptance boundary at the last clock of a slot, and abandoned conversions;
- late results that land in the following slot;
- starts in the final clock of a slot;
- dropped offers under back-pressure;
- a mid-slot stop followed by a restart.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  // Conversion handshake phase within one slot
  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_WAIT = 1'b1
  } conv_state_e;

  // Width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/acq_slot_timer.sv
module acq_slot_timer
  import acq_seq_pkg::*;
#(
  parameter int SLOT_CYCLES = 24,
  localparam int CNT_W = cnt_width(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             active_o,
  output logic [CNT_W-1:0] slot_cnt_o,
  output logic             slot_last_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  // Divider: counts clocks inside a slot; run is sampled only at the slot end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      cnt_q <= '0;
      if (run_i) active_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q    <= '0;
      active_q <= run_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o    = active_q;
  assign slot_cnt_o  = cnt_q;
  assign slot_last_o = active_q && (cnt_q == LAST);

  // R10: the sequencer only leaves the active state at the end of a slot
  assert_slot_end_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(cnt_q) == LAST);

endmodule

// File: rtl/acq_chan_stepper.sv
module acq_chan_stepper
  import acq_seq_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = cnt_width(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            slot_last_i,
  output logic [CH_W-1:0] chan_o
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] chan_next;

  // Wrap logic: a power-of-two channel count wraps for free
  generate
    if (NUM_CH == (1 << CH_W)) begin : g_pow2
      assign chan_next = chan_q + 1'b1;
    end else begin : g_cmp
      assign chan_next = (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (slot_last_i) begin
      chan_q <= run_i ? chan_next : '0;
    end
  end

  assign chan_o = chan_q;

  // R2: the select never moves inside a slot
  assert_sel_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> $past(slot_last_i));

endmodule

// File: rtl/acq_conv_ctrl.sv
module acq_conv_ctrl
  import acq_seq_pkg::*;
#(
  parameter int SLOT_CYCLES = 24,
  parameter int DATA_W = 12,
  parameter int CH_W = 5,
  parameter int SETTLE_W = 8,
  localparam int CNT_W = cnt_width(SLOT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  slot_cnt_i,
  input  logic              slot_last_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_start_o,
  output logic              adc_rd_o,
  output logic              cap_valid_o,
  output logic [DATA_W-1:0] cap_sample_o,
  output logic [CH_W-1:0]   cap_chan_o,
  output logic              cap_frame_o
);

  conv_state_e state_q;
  logic        start;
  logic        take;

  // Start fires when the in-slot count reaches the settling delay
  assign start = active_i && (int'(slot_cnt_i) == int'(settle_i));
  assign take  = (state_q == CONV_WAIT) && adc_done_i;

  // The window opens after the start and closes with the slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CONV_IDLE;
    end else begin
      unique case (state_q)
        CONV_IDLE: if (start && !slot_last_i) state_q <= CONV_WAIT;
        CONV_WAIT: if (adc_done_i || slot_last_i) state_q <= CONV_IDLE;
        default:   state_q <= CONV_IDLE;
      endcase
    end
  end

  assign adc_start_o  = start;
  assign adc_rd_o     = take;
  assign cap_valid_o  = take;
  assign cap_sample_o = adc_data_i;
  assign cap_chan_o   = chan_i;
  assign cap_frame_o  = (chan_i == '0);

  // R7: a result is never taken in the clock that starts a conversion
  assert_start_rd_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, take}));

  // R5: results are only read inside an active slot
  assert_rd_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> active_i);

endmodule

// File: rtl/acq_fifo_feed.sv
module acq_fifo_feed #(
  parameter int DATA_W = 12,
  parameter int CH_W = 5,
  localparam int OUT_W = DATA_W + CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid_i,
  input  logic [DATA_W-1:0] cap_sample_i,
  input  logic [CH_W-1:0]   cap_chan_i,
  input  logic              cap_frame_i,
  input  logic              fifo_ready_i,
  output logic              fifo_valid_o,
  output logic [OUT_W-1:0]  fifo_data_o,
  output logic              overflow_o
);

  logic             valid_q;
  logic [OUT_W-1:0] data_q;
  logic             ovf_q;

  // One-clock offer; a refused offer is lost and remembered
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= cap_valid_i;
      if (cap_valid_i) data_q <= {cap_frame_i, cap_chan_i, cap_sample_i};
      if (valid_q && !fifo_ready_i) ovf_q <= 1'b1;
    end
  end

  assign fifo_valid_o = valid_q;
  assign fifo_data_o  = data_q;
  assign overflow_o   = ovf_q;

  // R9: the overflow flag is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 12,
  parameter int SLOT_CYCLES = 24,
  parameter int SETTLE_W = 8,
  localparam int CH_W = cnt_width(NUM_CH),
  localparam int CNT_W = cnt_width(SLOT_CYCLES),
  localparam int OUT_W = DATA_W + CH_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [SETTLE_W-1:0] settle,
  output logic [CH_W-1:0]     mux_sel,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [DATA_W-1:0]   adc_data,
  output logic                adc_rd,
  output logic                fifo_valid,
  input  logic                fifo_ready,
  output logic [OUT_W-1:0]    fifo_data,
  output logic                overflow
);

  logic             active;
  logic [CNT_W-1:0] slot_cnt;
  logic             slot_last;
  logic             cap_valid;
  logic [DATA_W-1:0] cap_sample;
  logic [CH_W-1:0]  cap_chan;
  logic             cap_frame;

  acq_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .active_o   (active),
    .slot_cnt_o (slot_cnt),
    .slot_last_o(slot_last)
  );

  acq_chan_stepper #(.NUM_CH(NUM_CH)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .slot_last_i(slot_last),
    .chan_o     (mux_sel)
  );

  acq_conv_ctrl #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .DATA_W     (DATA_W),
    .CH_W       (CH_W),
    .SETTLE_W   (SETTLE_W)
  ) u_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .slot_cnt_i  (slot_cnt),
    .slot_last_i (slot_last),
    .settle_i    (settle),
    .chan_i      (mux_sel),
    .adc_done_i  (adc_done),
    .adc_data_i  (adc_data),
    .adc_start_o (adc_start),
    .adc_rd_o    (adc_rd),
    .cap_valid_o (cap_valid),
    .cap_sample_o(cap_sample),
    .cap_chan_o  (cap_chan),
    .cap_frame_o (cap_frame)
  );

  acq_fifo_feed #(.DATA_W(DATA_W), .CH_W(CH_W)) u_feed (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid_i (cap_valid),
    .cap_sample_i(cap_sample),
    .cap_chan_i  (cap_chan),
    .cap_frame_i (cap_frame),
    .fifo_ready_i(fifo_ready),
    .fifo_valid_o(fifo_valid),
    .fifo_data_o (fifo_data),
    .overflow_o  (overflow)
  );

  // R10: whenever the timer is idle the multiplexer rests on channel 0
  assert_idle_sel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> mux_sel == '0);

  // R5: every FIFO offer is preceded by a converter read
  assert_valid_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> $past(adc_rd));

endmodule

// File: tb/acq_sequencer_test.sv
`timescale 1ns/1ps
module acq_sequencer_test;

  localparam int SLOT = 24;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [7:0]  settle;
  logic [4:0]  mux_sel;
  logic        adc_start;
  logic        adc_done;
  logic [11:0] adc_data;
  logic        adc_rd;
  logic        fifo_valid;
  logic        fifo_ready;
  logic [17:0] fifo_data;
  logic        overflow;

  always #2 clk = ~clk;

  acq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .settle(settle),
    .mux_sel(mux_sel), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .adc_rd(adc_rd), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Vector: settle, latency, slots, ready, accepted, any start, overflow
  localparam logic [27:0] VECS [0:NVEC-1] = '{
    {8'd2,  8'd5,  8'd4,  1'b1, 1'b1, 1'b1, 1'b0},  // R4 R5 basic
    {8'd0,  8'd1,  8'd3,  1'b1, 1'b1, 1'b1, 1'b0},  // R4 zero settle
    {8'd10, 8'd13, 8'd3,  1'b1, 1'b1, 1'b1, 1'b0},  // R5 done in last clock
    {8'd10, 8'd14, 8'd3,  1'b1, 1'b0, 1'b1, 1'b0},  // R8 R7 late done
    {8'd23, 8'd1,  8'd2,  1'b1, 1'b0, 1'b1, 1'b0},  // R8 start in last clock
    {8'd30, 8'd2,  8'd2,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 settle beyond slot
    {8'd5,  8'd7,  8'd36, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 R6 wrap
    {8'd4,  8'd3,  8'd3,  1'b0, 1'b1, 1'b1, 1'b1},  // R9 drop
    {8'd4,  8'd3,  8'd2,  1'b1, 1'b1, 1'b1, 1'b1}   // R9 sticky
  };

  // Converter model and port monitor, all at the falling edge
  int          conv_lat = 1;
  logic        force_done = 1'b0;
  logic        mdl_done = 1'b0;
  logic [11:0] mdl_data = '0;
  int          cd = 0;
  logic [6:0]  st7 = '0;
  longint      cyc = 0;
  longint      chg_cyc = 0;
  bit          have_chg = 0;
  logic [4:0]  prev_mux = '0;
  int          start_cnt = 0;
  int          valid_cnt = 0;
  logic [17:0] exp_q [0:63];
  int          wr_p = 0;
  int          rd_p = 0;

  assign adc_done = mdl_done | force_done;
  assign adc_data = mdl_data;

  always @(negedge clk) begin
    cyc++;
    mdl_done = 1'b0;
    if (!rst_n) begin
      cd = 0;
      prev_mux = mux_sel;
    end else begin
      if (cd > 0) begin
        cd--;
        if (cd == 0) mdl_done = 1'b1;
      end
      if (mux_sel != prev_mux) begin
        if (mux_sel != 5'd0)
          chk(int'(mux_sel) == int'(prev_mux) + 1, "R3", "channel step",
              mux_sel, int'(prev_mux) + 1);
        if (have_chg && (cyc - chg_cyc) < 2 * SLOT)
          chk((cyc - chg_cyc) == SLOT, "R2", "slot length", cyc - chg_cyc, SLOT);
        chg_cyc  = cyc;
        have_chg = 1;
      end
      prev_mux = mux_sel;
      if (fifo_valid) begin
        valid_cnt++;
        chk(fifo_data[17] == (fifo_data[16:12] == 5'd0), "R6", "frame flag",
            fifo_data[17], fifo_data[16:12] == 5'd0);
        if (rd_p == wr_p) begin
          chk(1'b0, "R5", "unexpected fifo word", fifo_data, 0);
        end else begin
          chk(fifo_data == exp_q[rd_p % 64], "R5", "fifo word",
              fifo_data, exp_q[rd_p % 64]);
          rd_p++;
        end
      end
      if (adc_start) begin
        start_cnt++;
        if (have_chg && (cyc - chg_cyc) < SLOT)
          chk((cyc - chg_cyc) == longint'(settle), "R4", "start offset",
              cyc - chg_cyc, settle);
        mdl_data = {mux_sel, st7};
        if (int'(settle) + conv_lat <= SLOT - 1) begin
          exp_q[wr_p % 64] = {mux_sel == 5'd0, mux_sel, mux_sel, st7};
          wr_p++;
        end
        st7 = st7 + 7'd1;
        cd = conv_lat;
      end
    end
  end

  task automatic check_idle(input string req);
    chk(mux_sel == 5'd0, req, "mux_sel idle", mux_sel, 0);
    chk(adc_start == 1'b0 && adc_rd == 1'b0, req, "strobes idle",
        {adc_start, adc_rd}, 0);
    chk(fifo_valid == 1'b0, req, "fifo_valid idle", fifo_valid, 0);
    chk(overflow == 1'b0, req, "overflow clear", overflow, 0);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; settle = '0; fifo_ready = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      int s0, v0, ds, dv;
      v = VECS[i];
      settle     = v[27:20];
      conv_lat   = int'(v[19:12]);
      fifo_ready = v[3];
      s0 = start_cnt; v0 = valid_cnt;
      @(negedge clk) run = 1'b1;
      repeat (int'(v[11:4]) * SLOT) @(negedge clk);
      run = 1'b0;
      repeat (3 * SLOT) @(negedge clk);
      ds = start_cnt - s0; dv = valid_cnt - v0;
      chk((ds > 0) == v[1], "R4", "starts issued", ds, v[1]);
      if (v[2]) chk(dv == ds, "R5", "writes per start", dv, ds);
      else      chk(dv == 0, "R8", "abandoned writes", dv, 0);
      chk(rd_p == wr_p, "R7", "expected queue drained", wr_p - rd_p, 0);
      chk(overflow == v[0], "R9", "overflow flag", overflow, v[0]);
      chk(mux_sel == 5'd0, "R10", "parked select", mux_sel, 0);
    end

    // Reset clears the sticky flag
    fifo_ready = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);

    // R7: a stray done while idle produces nothing
    begin
      int v0;
      v0 = valid_cnt;
      force_done = 1'b1;
      @(negedge clk) force_done = 1'b0;
      repeat (4) @(negedge clk);
      chk(valid_cnt == v0, "R7", "stray done while idle", valid_cnt - v0, 0);
      chk(adc_rd == 1'b0, "R7", "no read strobe", adc_rd, 0);
    end

    // R10: stop mid-slot, then restart
    begin
      int s0, v0;
      settle = 8'd3; conv_lat = 4;
      s0 = start_cnt; v0 = valid_cnt;
      @(negedge clk) run = 1'b1;
      while (start_cnt < s0 + 3) @(negedge clk);
      run = 1'b0;
      repeat (2 * SLOT) @(negedge clk);
      chk(start_cnt - s0 == 3, "R10", "no start after stop", start_cnt - s0, 3);
      chk(valid_cnt - v0 == 3, "R10", "last slot still written", valid_cnt - v0, 3);
      chk(mux_sel == 5'd0, "R10", "select parked", mux_sel, 0);
      run = 1'b1;
      while (start_cnt < s0 + 4) @(negedge clk);
      chk(mux_sel == 5'd0, "R3", "restart channel", mux_sel, 0);
      run = 1'b0;
      repeat (3 * SLOT) @(negedge clk);
      chk(rd_p == wr_p, "R10", "restart sample delivered", wr_p - rd_p, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule